// File: doc/BRIEF.md
# Scaled Window Source Coordinate Stepper

This block walks the source image of one display window while the raster scans the screen. A raster timing source gives three single-cycle pulses: a frame pulse, a pulse before each line, and one strobe per screen pixel. The block counts screen columns and rows from these pulses. For every strobe that falls inside the window's output rectangle it produces the integer source column and row that the pixel should be fetched from. Each axis has its own fixed-point accumulator with 12 fractional bits. The horizontal accumulator reloads at every line and steps once per window pixel. The vertical accumulator reloads at every frame and steps once per window row. The integer part of each accumulator is limited to the last valid source index.

Software writes a set of shadow configuration words. An update request makes the whole set take effect together at the next frame pulse, so a frame never mixes old and new settings. The usual increment is input size × 4096 / max(output size − 1, 1), which maps the first and last output pixel to the two ends of the source.

Top module: `win_scale_stepper`

## Requirements
- R1: After reset, `out_valid`, `src_x` and `src_y` are 0, and the window is disabled until a configuration has been written and committed.
- R2: Writes with `cfg_we` go to shadow words selected by `cfg_addr`. Address 0 is the input size, address 1 the output size and address 2 the output position, each with horizontal in bits [15:0] and vertical in bits [31:16]. Address 3 holds the increments (horizontal [15:0], vertical [31:16]), address 4 the horizontal initial value [15:0], address 5 the vertical initial value [15:0], and address 6 the enable in bit 0. The active settings change only at a `frame_start` pulse.
- R3: A `frame_start` copies the shadow words to the active set only if `upd_req` has pulsed since the previous copy. Without such a request, the frame runs with the previous settings.
- R4: `out_valid` is 1 in the cycle after a `pix_stb` if and only if that pixel's screen column c and row r satisfy pos_x ≤ c < pos_x+out_w and pos_y ≤ r < pos_y+out_h. The window must also be enabled. Columns count strobes since the last `line_start`, and rows count `line_start` pulses since `frame_start`, both from 0.
- R5: With the enable bit 0, `out_valid` stays 0 for the whole frame.
- R6: For the k-th window pixel of a line (k = c − pos_x), `src_x` = (init_h + k·inc_h) >> 12, where 0x1000 is a step of one source pixel.
- R7: For window row j (j = r − pos_y), `src_y` = (init_v + j·inc_v) >> 12.
- R8: `src_x` is never above in_w − 1 and `src_y` never above in_h − 1. A larger accumulator value yields exactly that limit.
- R9: In a cycle after no `pix_stb`, `out_valid` is 0 and `src_x`/`src_y` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame pulse, before the first line |
| line_start | input | 1 | Line pulse, before the line's first strobe |
| pix_stb | input | 1 | One screen pixel |
| cfg_we | input | 1 | Shadow word write strobe |
| cfg_addr | input | 3 | Shadow word select |
| cfg_wdata | input | 32 | Shadow word data |
| upd_req | input | 1 | Request to commit the shadow set at the next frame pulse |
| out_valid | output | 1 | Source coordinate valid, one cycle after the strobe |
| src_x | output | CW | Source column |
| src_y | output | CW | Source row |

## Verification
The checker checks on every cycle the properties that need no arithmetic model. A valid always follows a strobe while the window is enabled. Coordinates never pass the active input size, outputs hold between strobes, and the active set changes only on a frame pulse. The exact DDA arithmetic, the window rectangle boundaries and the deferral of uncommitted writes are shown only by the bench's frames: directed identity, upscale, downscale with clamping and non-zero start values, followed by random window geometries with gaps between strobes.

// File: rtl/win_scale_pkg.sv
package win_scale_pkg;
   localparam int HALF_W = 16;
   typedef logic [HALF_W-1:0] half_t;

   typedef struct packed {
      logic  en;
      half_t in_w;
      half_t in_h;
      half_t out_w;
      half_t out_h;
      half_t pos_x;
      half_t pos_y;
      half_t inc_h;
      half_t inc_v;
      half_t init_h;
      half_t init_v;
   } wcfg_t;

   typedef enum logic [2:0] {
      SEL_IN_SIZE  = 3'd0,
      SEL_OUT_SIZE = 3'd1,
      SEL_OUT_POS  = 3'd2,
      SEL_STEP     = 3'd3,
      SEL_INIT_H   = 3'd4,
      SEL_INIT_V   = 3'd5,
      SEL_CTRL     = 3'd6
   } reg_sel_e;
endpackage

// File: rtl/win_scale_cfg.sv
module win_scale_cfg
   import win_scale_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   input  logic        upd_req,
   input  logic        frame_start,
   output wcfg_t       act,
   output wcfg_t       nxt,
   output logic        pend
);
   localparam half_t CMASK = half_t'((32'd1 << CW) - 1);

   wcfg_t shadow;
   half_t lo_c, hi_c;

   assign lo_c = cfg_wdata[15:0]  & CMASK;
   assign hi_c = cfg_wdata[31:16] & CMASK;
   assign nxt  = pend ? shadow : act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         act    <= '0;
         pend   <= 1'b0;
      end else begin
         if (cfg_we) begin
            case (reg_sel_e'(cfg_addr))
               SEL_IN_SIZE:  begin shadow.in_w  <= lo_c; shadow.in_h  <= hi_c; end
               SEL_OUT_SIZE: begin shadow.out_w <= lo_c; shadow.out_h <= hi_c; end
               SEL_OUT_POS:  begin shadow.pos_x <= lo_c; shadow.pos_y <= hi_c; end
               SEL_STEP:     begin shadow.inc_h <= cfg_wdata[15:0]; shadow.inc_v <= cfg_wdata[31:16]; end
               SEL_INIT_H:   shadow.init_h <= cfg_wdata[15:0];
               SEL_INIT_V:   shadow.init_v <= cfg_wdata[15:0];
               SEL_CTRL:     shadow.en <= cfg_wdata[0];
               default:      ;
            endcase
         end
         if (frame_start) begin
            act <= nxt;
            if (pend) pend <= 1'b0;
         end
         if (upd_req) pend <= 1'b1;
      end
   end
endmodule

// File: rtl/win_scale_raster.sv
module win_scale_raster #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          line_start,
   input  logic          pix_stb,
   input  logic [CW-1:0] pos_x,
   input  logic [CW-1:0] pos_y,
   input  logic [CW-1:0] out_w,
   input  logic [CW-1:0] out_h,
   output logic          x_in,
   output logic          y_in
);
   logic [CW-1:0] col, row;
   logic          seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col  <= '0;
         row  <= '0;
         seen <= 1'b0;
      end else if (frame_start) begin
         col  <= '0;
         row  <= '0;
         seen <= 1'b0;
      end else if (line_start) begin
         col  <= '0;
         if (seen) row <= row + 1'b1;
         seen <= 1'b1;
      end else if (pix_stb) begin
         col <= col + 1'b1;
      end
   end

   assign x_in = ({1'b0, col} >= {1'b0, pos_x}) &&
                 ({1'b0, col} <  ({1'b0, pos_x} + {1'b0, out_w}));
   assign y_in = seen &&
                 ({1'b0, row} >= {1'b0, pos_y}) &&
                 ({1'b0, row} <  ({1'b0, pos_y} + {1'b0, out_h}));
endmodule

// File: rtl/win_scale_axis.sv
module win_scale_axis #(
   parameter int CW   = 12,
   parameter int FRAC = 12,
   parameter int ACCW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload,
   input  logic [15:0]   reload_val,
   input  logic          step,
   input  logic [15:0]   inc,
   input  logic [CW-1:0] size,
   output logic [CW-1:0] coord
);
   localparam int IPW = ACCW - FRAC;

   logic [ACCW-1:0] acc;
   logic [IPW-1:0]  ipart;

   always_ff @(posedge clk) begin
      if (!rst_n)      acc <= '0;
      else if (reload) acc <= {{(ACCW-16){1'b0}}, reload_val};
      else if (step)   acc <= acc + {{(ACCW-16){1'b0}}, inc};
   end

   assign ipart = acc[ACCW-1:FRAC];

   always_comb begin
      if (size == '0)
         coord = '0;
      else if (ipart >= {{(IPW-CW){1'b0}}, size})
         coord = size - 1'b1;
      else
         coord = ipart[CW-1:0];
   end
endmodule

// File: rtl/win_scale_stepper.sv
module win_scale_stepper
   import win_scale_pkg::*;
#(
   parameter int CW   = 12,
   parameter int FRAC = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          line_start,
   input  logic          pix_stb,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic          upd_req,
   output logic          out_valid,
   output logic [CW-1:0] src_x,
   output logic [CW-1:0] src_y
);
   localparam int ACCW   = CW + HALF_W;
   localparam int N_AXIS = 2;

   if (CW < 2 || CW > HALF_W) begin : g_bad_cw
      $error("CW must be between 2 and 16");
   end
   if (FRAC < 1 || FRAC >= HALF_W) begin : g_bad_frac
      $error("FRAC must leave integer bits in a 16-bit increment");
   end

   wcfg_t act_cfg, nxt_cfg;
   logic  upd_pend;
   logic  x_in, y_in, hit;
   logic  unused_cfg;

   win_scale_cfg #(.CW(CW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .upd_req(upd_req), .frame_start(frame_start),
      .act(act_cfg), .nxt(nxt_cfg), .pend(upd_pend)
   );

   win_scale_raster #(.CW(CW)) u_raster (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .line_start(line_start), .pix_stb(pix_stb),
      .pos_x(act_cfg.pos_x[CW-1:0]), .pos_y(act_cfg.pos_y[CW-1:0]),
      .out_w(act_cfg.out_w[CW-1:0]), .out_h(act_cfg.out_h[CW-1:0]),
      .x_in(x_in), .y_in(y_in)
   );

   assign hit = pix_stb & x_in & y_in;

   logic          ax_rel  [N_AXIS];
   logic          ax_step [N_AXIS];
   half_t         ax_rval [N_AXIS];
   half_t         ax_inc  [N_AXIS];
   logic [CW-1:0] ax_size [N_AXIS];
   logic [CW-1:0] ax_crd  [N_AXIS];

   for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
      if (a == 0) begin : g_horiz
         assign ax_rel[a]  = line_start;
         assign ax_rval[a] = act_cfg.init_h;
         assign ax_step[a] = hit;
         assign ax_inc[a]  = act_cfg.inc_h;
         assign ax_size[a] = act_cfg.in_w[CW-1:0];
      end else begin : g_vert
         assign ax_rel[a]  = frame_start;
         assign ax_rval[a] = nxt_cfg.init_v;
         assign ax_step[a] = line_start & y_in;
         assign ax_inc[a]  = act_cfg.inc_v;
         assign ax_size[a] = act_cfg.in_h[CW-1:0];
      end
      win_scale_axis #(.CW(CW), .FRAC(FRAC), .ACCW(ACCW)) u_axis (
         .clk(clk), .rst_n(rst_n), .reload(ax_rel[a]), .reload_val(ax_rval[a]),
         .step(ax_step[a]), .inc(ax_inc[a]), .size(ax_size[a]),
         .coord(ax_crd[a])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         src_x     <= '0;
         src_y     <= '0;
      end else begin
         out_valid <= hit & act_cfg.en;
         if (hit) begin
            src_x <= ax_crd[0];
            src_y <= ax_crd[1];
         end
      end
   end

   assign unused_cfg = ^{act_cfg, nxt_cfg, upd_pend};
endmodule

// File: rtl/win_scale_stepper_chk.sv
module win_scale_stepper_chk
   import win_scale_pkg::*;
#(
   parameter int CW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pix_stb,
   input logic          frame_start,
   input logic          out_valid,
   input logic [CW-1:0] src_x,
   input logic [CW-1:0] src_y,
   input wcfg_t         act
);
   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(pix_stb)); // R4
   AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(act.en)); // R5
   AST_X_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(act.in_w) != '0) |-> (src_x < $past(act.in_w[CW-1:0]))); // R8
   AST_Y_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(act.in_h) != '0) |-> (src_y < $past(act.in_h[CW-1:0]))); // R8
   AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act)); // R2
   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_stb |=> (!out_valid && $stable(src_x) && $stable(src_y))); // R9
endmodule

bind win_scale_stepper win_scale_stepper_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .frame_start(frame_start),
   .out_valid(out_valid), .src_x(src_x), .src_y(src_y), .act(act_cfg)
);

// File: tb/win_scale_stepper_tb.sv
`timescale 1ns/1ps
module win_scale_stepper_tb;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0, line_start = 1'b0, pix_stb = 1'b0;
   logic          cfg_we = 1'b0, upd_req = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          out_valid;
   logic [CW-1:0] src_x, src_y;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model: shadow and active settings, indices
   // 0 in_w 1 in_h 2 out_w 3 out_h 4 pos_x 5 pos_y 6 inc_h 7 inc_v 8 init_h 9 init_v 10 en
   longint sh [11];
   longint ac [11];
   bit     pend = 1'b0;

   always #2 clk = ~clk;

   win_scale_stepper #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
      .pix_stb(pix_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .upd_req(upd_req), .out_valid(out_valid), .src_x(src_x), .src_y(src_y)
   );

   function automatic longint exp_coord(longint init, longint inc, longint k, longint size);
      longint v;
      v = (init + k * inc) >> 12;
      if (size == 0) return 0;
      if (v > size - 1) return size - 1;
      return v;
   endfunction

   function automatic longint soft_inc(longint insz, longint outsz);
      longint d, v;
      d = (outsz - 1 > 1) ? outsz - 1 : 1;
      v = insz * 4096 / d;
      return (v > 65535) ? 65535 : v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act_v, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
      end
   endtask

   task automatic wr(input int addr, input longint lo, input longint hi);
      cfg_we = 1'b1; cfg_addr = 3'(addr);
      cfg_wdata = {hi[15:0], lo[15:0]};
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // R2: address/field placement as stated in the requirement
   task automatic set_cfg(input longint iw, ih, ow, oh, px, py, ch, cv, i0h, i0v, en);
      wr(0, iw, ih); wr(1, ow, oh); wr(2, px, py); wr(3, ch, cv);
      wr(4, i0h, 0); wr(5, i0v, 0); wr(6, en, 0);
      sh[0] = iw; sh[1] = ih; sh[2] = ow; sh[3] = oh; sh[4] = px; sh[5] = py;
      sh[6] = ch; sh[7] = cv; sh[8] = i0h; sh[9] = i0v; sh[10] = en;
   endtask

   task automatic request_update();
      upd_req = 1'b1; @(posedge clk); @(negedge clk); upd_req = 1'b0;
      pend = 1'b1;
   endtask

   task automatic run_frame(input int rows, input int cols, input int gap_pct,
                            input string tv, input string tx, input string ty);
      longint px, py, prev_x, prev_y;
      bit hit, ev;
      frame_start = 1'b1; @(posedge clk); @(negedge clk); frame_start = 1'b0;
      if (pend) begin
         for (int i = 0; i < 11; i++) ac[i] = sh[i];
         pend = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      for (int r = 0; r < rows; r++) begin
         line_start = 1'b1; @(posedge clk); @(negedge clk); line_start = 1'b0;
         for (int c = 0; c < cols; c++) begin
            if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
               prev_x = src_x; prev_y = src_y;
               @(posedge clk); @(negedge clk);
               check(!out_valid && src_x == prev_x && src_y == prev_y, "R9",
                     "hold after idle cycle", {out_valid, src_x, src_y},
                     {1'b0, CW'(prev_x), CW'(prev_y)});
            end
            pix_stb = 1'b1; @(posedge clk); @(negedge clk); pix_stb = 1'b0;
            px = c - ac[4]; py = r - ac[5];
            hit = (px >= 0) && (px < ac[2]) && (py >= 0) && (py < ac[3]);
            ev  = hit && (ac[10] != 0);
            check(out_valid == ev, tv, $sformatf("valid r%0d c%0d", r, c), out_valid, ev);
            if (hit) begin
               check(src_x == exp_coord(ac[8], ac[6], px, ac[0]), tx,
                     $sformatf("src_x r%0d c%0d", r, c), src_x,
                     exp_coord(ac[8], ac[6], px, ac[0]));
               check(src_y == exp_coord(ac[9], ac[7], py, ac[1]), ty,
                     $sformatf("src_y r%0d c%0d", r, c), src_y,
                     exp_coord(ac[9], ac[7], py, ac[1]));
            end
         end
         @(posedge clk); @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i < 11; i++) begin sh[i] = 0; ac[i] = 0; end
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(src_x == '0, "R1", "src_x after reset", src_x, 0);
      check(src_y == '0, "R1", "src_y after reset", src_y, 0);
      run_frame(3, 4, 0, "R1", "R1", "R1");

      // R6/R7: one-to-one mapping with unit steps
      set_cfg(8, 6, 8, 6, 0, 0, 4096, 4096, 0, 0, 1);
      request_update();
      run_frame(8, 10, 0, "R4", "R6", "R7");

      // R4/R6/R7: upscale with offset window and computed increments
      set_cfg(5, 4, 12, 9, 3, 2, soft_inc(5, 12), soft_inc(4, 9), 0, 0, 1);
      request_update();
      run_frame(14, 20, 20, "R4", "R6", "R7");

      // R8: downscale with oversized steps, clamped at the last source index
      set_cfg(6, 5, 4, 3, 1, 1, 16'h3000, 16'h3000, 0, 0, 1);
      request_update();
      run_frame(6, 8, 0, "R4", "R8", "R8");

      // R6/R7: non-zero starting values
      set_cfg(20, 20, 6, 5, 0, 0, 16'h1800, 16'h0c00, 16'h1800, 16'h2400, 1);
      request_update();
      run_frame(7, 8, 0, "R4", "R6", "R7");

      // R3: new shadow values without a request leave the frame unchanged
      set_cfg(3, 3, 2, 2, 5, 5, 4096, 4096, 0, 0, 1);
      run_frame(7, 8, 0, "R3", "R3", "R3");
      request_update();
      run_frame(8, 8, 0, "R3", "R3", "R3");

      // R5: disabled window gives no valid output
      set_cfg(8, 8, 8, 8, 0, 0, 4096, 4096, 0, 0, 0);
      request_update();
      run_frame(9, 9, 10, "R5", "R6", "R7");

      // random geometries
      for (int t = 0; t < 24; t++) begin
         longint iw, ih, ow, oh;
         iw = 1 + $urandom % 20; ih = 1 + $urandom % 16;
         ow = 1 + $urandom % 16; oh = 1 + $urandom % 10;
         set_cfg(iw, ih, ow, oh, $urandom % 12, $urandom % 8,
                 soft_inc(iw, ow), soft_inc(ih, oh),
                 ($urandom % 3 == 0) ? $urandom % 16'h2000 : 0,
                 ($urandom % 3 == 0) ? $urandom % 16'h2000 : 0,
                 ($urandom % 5 != 0) ? 1 : 0);
         request_update();
         run_frame(14, 24, 15, "R4", "R6", "R7");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule